// File: doc/BRIEF.md
# Load/Store Lane Aligner

This block sits between the integer pipeline and a word-addressed data memory whose width is a multiple of 32 bits (32 by default). A request names a base address, an offset, an access size (byte, half or word), a direction and, for loads, whether the result is unsigned. The block adds base and offset, turns the sum into a word index and a byte-lane number, and checks the natural alignment of the access. For a store it copies the low part of the source data into every byte lane and raises one write strobe for each byte being written. The memory then only has to honour the strobes.

For a load, the block keeps the lane, size and sign mode of the last load it issued. When the memory hands back the addressed word, the block selects the addressed byte, half or word and sign- or zero-extends it to the full data width. A request that breaks alignment only raises an error flag. It produces no memory access.

With the default `PIPE=1`, request outputs are registered and appear one clock after the request. Load results are combinational from the response word.

Top module: `ldst_lane_align`

## Requirements
- R1: The effective address is `req_base + req_offset` (modulo 2^32). `mem_addr` is that sum shifted right by 2. It appears in the cycle after `req_valid` is sampled high.
- R2: Size code 0 is a byte, 1 is a half and 2 is a word. An aligned byte store raises `mem_wstrb = 4'b0001 << ea[1:0]`, and the strobe count of any store is 1, 2 or 4.
- R3: An aligned half store raises `4'b0011` at `ea[1:0]=0` and `4'b1100` at `ea[1:0]=2`. A word store at `ea[1:0]=0` raises `4'b1111`.
- R4: An access is misaligned when it is a half with `ea[0]=1`, a word with `ea[1:0]!=0`, or uses size code 3. For such an access `misalign` is 1, and `mem_we`, `mem_rd` and `mem_wstrb` are all 0.
- R5: Store data is replicated. A byte store puts `wdata[7:0]` in all four lanes, a half store puts `wdata[15:0]` in both halves, and a word store passes `wdata[31:0]`. Higher source bits have no effect.
- R6: `mem_we` and `mem_rd` are never both high. `mem_wstrb` is 0 whenever `mem_we` is 0. During reset, and in any cycle after a cycle with `req_valid` low, `mem_we`, `mem_rd` and `misalign` are 0.
- R7: A byte load returns the byte at the lane of the last issued load. The byte is sign-extended when `req_unsigned=0` and zero-extended when it is 1.
- R8: A half load returns the addressed 16 bits, sign-extended or zero-extended by the same rule.
- R9: A word load returns all 32 bits unchanged, whatever the value of `req_unsigned`.
- R10: `ld_valid` equals `rsp_valid` in the same cycle. `ld_data` is 0 whenever `rsp_valid` is 0, including during reset.
- R11: A misaligned load does not replace the kept lane, size and sign of the previous good load. A response that arrives after it is decoded with the earlier settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 reserved |
| req_unsigned | input | 1 | Load result zero-extended when 1 |
| req_base | input | ADDR_W | Base address |
| req_offset | input | ADDR_W | Offset added to the base |
| req_wdata | input | DATA_W | Store source data |
| mem_addr | output | ADDR_W-2 | Word index to the memory |
| mem_rd | output | 1 | Aligned load issued |
| mem_we | output | 1 | Aligned store issued |
| mem_wstrb | output | DATA_W/8 | Per-byte write strobes |
| mem_wdata | output | DATA_W | Lane-replicated write data |
| misalign | output | 1 | Request broke alignment |
| rsp_valid | input | 1 | Memory read word present |
| rsp_word | input | DATA_W | Word returned by memory |
| ld_valid | output | 1 | Load result present |
| ld_data | output | DATA_W | Extended load result |

## Verification
Every combination of size code and low address bits is swept for stores and loads, in both sign modes, against a byte-array memory. Loaded bytes carry both set and clear top bits, so a design that swapped sign and zero extension, or extended from the wrong bit, returns wrong upper bits. Each store is read back through loads at every lane: a wrong strobe shift or missing replication corrupts neighbouring bytes or leaves stale ones. Negative offsets exercise the address adder. A misaligned request is placed between a load and its late response, which catches a design that leaks strobes on bad accesses or lets a rejected load overwrite the kept lane.

// File: rtl/ldst_align_pkg.sv
package ldst_align_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   // bytes moved by an access; 0 marks the reserved code
   function automatic int unsigned size_bytes(acc_size_e sz);
      case (sz)
         SZ_BYTE: return 1;
         SZ_HALF: return 2;
         SZ_WORD: return 4;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/ldst_addr_decode.sv
module ldst_addr_decode
   import ldst_align_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4,
   parameter int OFS_W  = 2
) (
   input  logic [ADDR_W-1:0]       base,
   input  logic [ADDR_W-1:0]       offset,
   input  acc_size_e               size,
   output logic [ADDR_W-OFS_W-1:0] word_addr,
   output logic [OFS_W-1:0]        lane,
   output logic [LANES-1:0]        lane_mask,
   output logic                    bad
);

   logic [ADDR_W-1:0] eff;
   int unsigned       nb;

   assign eff       = base + offset;
   assign word_addr = eff[ADDR_W-1:OFS_W];
   assign lane      = eff[OFS_W-1:0];

   always_comb begin
      nb  = size_bytes(size);
      bad = (size == SZ_RSVD) || ((lane & OFS_W'(nb - 1)) != '0);
      lane_mask = '0;
      for (int i = 0; i < LANES; i++) begin
         if (!bad && (i >= int'(lane)) && (i < int'(lane) + int'(nb)))
            lane_mask[i] = 1'b1;
      end
   end

endmodule

// File: rtl/ldst_store_steer.sv
module ldst_store_steer
   import ldst_align_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANES  = 4
) (
   input  logic [DATA_W-1:0] wdata,
   input  acc_size_e         size,
   output logic [DATA_W-1:0] lanes
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_comb begin
         case (size)
            SZ_BYTE: lanes[8*i +: 8] = wdata[7:0];
            SZ_HALF: lanes[8*i +: 8] = wdata[8*(i%2) +: 8];
            default: lanes[8*i +: 8] = wdata[8*(i%4) +: 8];
         endcase
      end
   end

endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
   import ldst_align_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int OFS_W  = 2
) (
   input  logic [DATA_W-1:0] word,
   input  logic [OFS_W-1:0]  lane,
   input  acc_size_e         size,
   input  logic              uns,
   output logic [DATA_W-1:0] data
);

   logic [DATA_W-1:0] shifted;
   int unsigned       nbits;
   logic              fill;

   assign shifted = word >> {lane, 3'b000};

   always_comb begin
      nbits = 8 * size_bytes(size);
      if (nbits == 0) nbits = 32;
      fill = ~uns & shifted[nbits-1];
      for (int b = 0; b < DATA_W; b++)
         data[b] = (b < int'(nbits)) ? shifted[b] : fill;
   end

endmodule

// File: rtl/ldst_lane_align.sv
module ldst_lane_align
   import ldst_align_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter bit PIPE   = 1'b1,
   localparam int LANES = DATA_W / 8,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_store,
   input  logic [1:0]              req_size,
   input  logic                    req_unsigned,
   input  logic [ADDR_W-1:0]       req_base,
   input  logic [ADDR_W-1:0]       req_offset,
   input  logic [DATA_W-1:0]       req_wdata,
   output logic [ADDR_W-OFS_W-1:0] mem_addr,
   output logic                    mem_rd,
   output logic                    mem_we,
   output logic [LANES-1:0]        mem_wstrb,
   output logic [DATA_W-1:0]       mem_wdata,
   output logic                    misalign,
   input  logic                    rsp_valid,
   input  logic [DATA_W-1:0]       rsp_word,
   output logic                    ld_valid,
   output logic [DATA_W-1:0]       ld_data
);

   if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power of two of at least 32");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr_w
      $error("ADDR_W must exceed the lane index width");
   end

   acc_size_e               size_in;
   logic [ADDR_W-OFS_W-1:0] word_addr;
   logic [OFS_W-1:0]        lane;
   logic [LANES-1:0]        lane_mask;
   logic                    bad;
   logic [DATA_W-1:0]       steered;

   assign size_in = acc_size_e'(req_size);

   ldst_addr_decode #(.ADDR_W(ADDR_W), .LANES(LANES), .OFS_W(OFS_W)) u_dec (
      .base(req_base), .offset(req_offset), .size(size_in),
      .word_addr(word_addr), .lane(lane), .lane_mask(lane_mask), .bad(bad)
   );

   ldst_store_steer #(.DATA_W(DATA_W), .LANES(LANES)) u_steer (
      .wdata(req_wdata), .size(size_in), .lanes(steered)
   );

   // next-state of the request outputs
   logic                    nx_we, nx_rd, nx_mis;
   logic [LANES-1:0]        nx_strb;
   logic [DATA_W-1:0]       nx_wdata;
   logic [ADDR_W-OFS_W-1:0] nx_addr;

   assign nx_we    = req_valid & req_store & ~bad;
   assign nx_rd    = req_valid & ~req_store & ~bad;
   assign nx_mis   = req_valid & bad;
   assign nx_strb  = nx_we ? lane_mask : '0;
   assign nx_wdata = nx_we ? steered : '0;
   assign nx_addr  = req_valid ? word_addr : '0;

   if (PIPE) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_rd    <= 1'b0;
            misalign  <= 1'b0;
            mem_wstrb <= '0;
            mem_wdata <= '0;
            mem_addr  <= '0;
         end else begin
            mem_we    <= nx_we;
            mem_rd    <= nx_rd;
            misalign  <= nx_mis;
            mem_wstrb <= nx_strb;
            mem_wdata <= nx_wdata;
            mem_addr  <= nx_addr;
         end
      end
   end else begin : g_comb_out
      assign mem_we    = nx_we;
      assign mem_rd    = nx_rd;
      assign misalign  = nx_mis;
      assign mem_wstrb = nx_strb;
      assign mem_wdata = nx_wdata;
      assign mem_addr  = nx_addr;
   end

   // settings of the last good load, used to decode its response
   logic [OFS_W-1:0] keep_lane;
   acc_size_e        keep_size;
   logic             keep_uns;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_lane <= '0;
         keep_size <= SZ_WORD;
         keep_uns  <= 1'b0;
      end else if (nx_rd) begin
         keep_lane <= lane;
         keep_size <= size_in;
         keep_uns  <= req_unsigned;
      end
   end

   logic [DATA_W-1:0] extracted;

   ldst_load_extract #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_ext (
      .word(rsp_word), .lane(keep_lane), .size(keep_size),
      .uns(keep_uns), .data(extracted)
   );

   assign ld_valid = rsp_valid;
   assign ld_data  = rsp_valid ? extracted : '0;

endmodule

// File: rtl/ldst_lane_align_chk.sv
module ldst_lane_align_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter bit PIPE   = 1'b1,
   localparam int LANES = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              mem_we,
   input logic              mem_rd,
   input logic              misalign,
   input logic [LANES-1:0]  mem_wstrb,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              ld_valid,
   input logic [DATA_W-1:0] ld_data
);

   AST_STRB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we |-> mem_wstrb == '0);                                        // R6
   AST_RD_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_rd));                                                // R6
   AST_MIS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (!mem_we && !mem_rd && mem_wstrb == '0));               // R4
   AST_STRB_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($countones(mem_wstrb) == 1 || $countones(mem_wstrb) == 2
                  || $countones(mem_wstrb) == 4));                         // R2
   AST_BYTE_REPL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $countones(mem_wstrb) == 1)
         |-> mem_wdata == {LANES{mem_wdata[7:0]}});                        // R5
   AST_LD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |-> ld_data == '0);                                        // R10
   AST_ISSUE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (PIPE && (mem_we || mem_rd || misalign)) |-> $past(req_valid));      // R1
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (PIPE && !$past(req_valid)) |-> (!mem_we && !mem_rd && !misalign));  // R6

endmodule

bind ldst_lane_align ldst_lane_align_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIPE(PIPE)
) u_chk (.*);

// File: tb/ldst_lane_align_test.sv
module ldst_lane_align_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic        req_unsigned = 1'b0;
   logic [31:0] req_base = '0;
   logic [31:0] req_offset = '0;
   logic [31:0] req_wdata = '0;
   logic [29:0] mem_addr;
   logic        mem_rd, mem_we, misalign;
   logic [3:0]  mem_wstrb;
   logic [31:0] mem_wdata;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_word = '0;
   logic        ld_valid;
   logic [31:0] ld_data;

   int  nvec = 0;
   int  nfail = 0;
   bit  done = 1'b0;
   logic [7:0] mem_b [0:63];

   always #10 clk = ~clk;

   ldst_lane_align uut (.*);

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] word_at(logic [31:0] ea);
      int w = int'(ea[5:2]) * 4;
      return {mem_b[w+3], mem_b[w+2], mem_b[w+1], mem_b[w]};
   endfunction

   function automatic logic [31:0] exp_load(logic [31:0] ea, logic [1:0] sz, bit uns);
      int a = int'(ea[5:0]);
      logic [7:0]  b = mem_b[a];
      logic [15:0] h;
      if (sz == 2'd0) return uns ? {24'h0, b} : {{24{b[7]}}, b};
      if (sz == 2'd1) begin
         h = {mem_b[a+1], mem_b[a]};
         return uns ? {16'h0, h} : {{16{h[15]}}, h};
      end
      return {mem_b[a+3], mem_b[a+2], mem_b[a+1], mem_b[a]};
   endfunction

   function automatic bit is_bad(logic [31:0] ea, logic [1:0] sz);
      return (sz == 2'd3) || (sz == 2'd1 && ea[0]) || (sz == 2'd2 && ea[1:0] != 2'd0);
   endfunction

   task automatic do_op(bit st, logic [1:0] sz, bit uns, logic [31:0] base,
                        logic [31:0] off, logic [31:0] wd);
      logic [31:0] ea = base + off;
      bit          bad = is_bad(ea, sz);
      logic [3:0]  strb = 4'h0;
      logic [31:0] ewd = 32'h0;
      logic [31:0] eld;
      string       ltag;
      if (st && !bad) begin
         strb = (sz == 2'd0) ? (4'b0001 << ea[1:0]) :
                (sz == 2'd1) ? (4'b0011 << ea[1:0]) : 4'b1111;
         ewd  = (sz == 2'd0) ? {4{wd[7:0]}} : (sz == 2'd1) ? {2{wd[15:0]}} : wd;
      end
      req_store = st; req_size = sz; req_unsigned = uns;
      req_base = base; req_offset = off; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R1", "word address", {2'b00, mem_addr}, {2'b00, ea[31:2]});
      check("R4", "misalign flag", {31'h0, misalign}, {31'h0, bad});
      check("R6", "write enable", {31'h0, mem_we}, {31'h0, st && !bad});
      check("R6", "read enable", {31'h0, mem_rd}, {31'h0, !st && !bad});
      check(bad ? "R4" : (sz == 2'd0 ? "R2" : "R3"), "strobes",
            {28'h0, mem_wstrb}, {28'h0, strb});
      check("R5", "write data", mem_wdata, ewd);
      if (st) begin
         for (int i = 0; i < 4; i++)
            if (mem_wstrb[i]) mem_b[int'(mem_addr[3:0]) * 4 + i] = mem_wdata[8*i +: 8];
      end else if (!bad) begin
         eld = exp_load(ea, sz, uns);
         ltag = (sz == 2'd0) ? "R7" : (sz == 2'd1) ? "R8" : "R9";
         rsp_word = word_at(ea);
         rsp_valid = 1'b1;
         #1;
         check("R10", "load valid", {31'h0, ld_valid}, 32'h1);
         check(ltag, "load data", ld_data, eld);
      end
      @(negedge clk);
      rsp_valid = 1'b0;
      rsp_word = 32'hDEAD_BEEF;
      #1;
      check("R10", "idle load data", ld_data, 32'h0);
      check("R6", "idle request outputs", {29'h0, mem_we, mem_rd, misalign}, 32'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL R1 watchdog: got %0d cycles expected fewer", 20000);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] ea;
      for (int i = 0; i < 64; i++) mem_b[i] = 8'(i * 37 + 5);

      repeat (3) @(negedge clk);
      rsp_word = 32'hFFFF_FFFF;
      #1;
      check("R6", "reset request outputs",
            {22'h0, mem_we, mem_rd, misalign, mem_wstrb, 3'h0}, 32'h0);
      check("R6", "reset write data", mem_wdata, 32'h0);
      check("R10", "reset load data", ld_data, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // stores at every size and alignment, reached through a negative offset
      for (int sz = 0; sz < 4; sz++)
         for (int a = 0; a < 4; a++)
            do_op(1'b1, 2'(sz), 1'b0, 32'h0000_0030 + 32'(sz * 4),
                  32'hFFFF_FFF0 + 32'(a), 32'h9E37_79B9 ^ 32'(sz * 32'h0101_0111 + a * 32'h1F));

      // loads at every size, alignment and sign mode in three regions (R7 R8 R9)
      for (int r = 0; r < 3; r++)
         for (int sz = 0; sz < 4; sz++)
            for (int a = 0; a < 4; a++)
               for (int u = 0; u < 2; u++)
                  do_op(1'b0, 2'(sz), u[0], 32'(r * 24 + 4), 32'(a), 32'h0);

      // upper source bits ignored for narrow stores (R5), read back as a word
      do_op(1'b1, 2'd0, 1'b0, 32'h8, 32'h1, 32'hFFFF_FF5A);
      do_op(1'b1, 2'd1, 1'b0, 32'h8, 32'h2, 32'h1234_C3A0);
      do_op(1'b0, 2'd2, 1'b1, 32'h8, 32'h0, 32'h0);

      // R11: a misaligned load between a load and its late response
      ea = 32'h23;
      req_store = 1'b0; req_size = 2'd0; req_unsigned = 1'b0;
      req_base = ea; req_offset = 32'h0; req_valid = 1'b1;
      @(negedge clk);
      check("R11", "first load issued", {31'h0, mem_rd}, 32'h1);
      req_size = 2'd1; req_unsigned = 1'b1; req_base = 32'h21;
      @(negedge clk);
      req_valid = 1'b0;
      check("R11", "misaligned load flagged", {30'h0, misalign, mem_rd}, 32'h2);
      rsp_word = word_at(ea);
      rsp_valid = 1'b1;
      #1;
      check("R11", "late response decode", ld_data, exp_load(ea, 2'd0, 1'b0));
      @(negedge clk);
      rsp_valid = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule